// File: doc/BRIEF.md
# Block-Granular SRAM Security Guard

This block sits in front of an on-chip SRAM and decides, for every access, whether the access may reach the memory. The SRAM is divided into 512-byte blocks. A bitmap holds one bit per block, and a bit of 1 marks that block as secure. Each request carries an address, an access kind (read, write or instruction fetch) and the secure attribute of the requester. A secure requester touching a non-secure block, or a non-secure requester touching a secure block, is judged against a small control word. Illegal requests are held back from the memory, blocked reads return zero, and the block raises an event pulse and a sticky flag.

A simple word-addressed register bus programs the control word, the status flag and the bitmap words. The control word carries three fields. The first is a lock that, once set, freezes the control word until reset. The second is a waiver that lets secure data accesses into non-secure blocks (secure fetches stay illegal). The third inverts the clock-security output. That output tells a clock controller whether the SRAM clocks must be treated as secure. It is derived from whether any block is marked secure.

`SRAM_BYTES` must be a power of two and at least 16 KiB, so that the bitmap fills whole 32-bit words.

Top module: `sram_blk_guard`

## Requirements
- R1: After reset, the control word, the status word and every bitmap word read as 0, `clk_secure` is 0 and `illegal_pulse` is 0.
- R2: Once control bit 0 (lock) is written as 1, it stays 1, and every later write to the control word (offset 0) leaves all of its fields unchanged until reset.
- R3: The control word at register offset 0 holds the lock at bit 0, the invert field at bit 30 and the detection waiver at bit 31. All other bits read as 0.
- R4: With the waiver at 0, a secure read (`acc_kind` 0) or write (`acc_kind` 1) to a non-secure block is blocked.
- R5: With the waiver at 1, a secure read or write to a non-secure block is allowed.
- R6: A secure fetch (`acc_kind` 2) from a non-secure block is blocked whatever the waiver holds.
- R7: A non-secure access of any kind to a secure block is blocked. A non-secure access to a non-secure block is allowed, and so is a secure access to a secure block.
- R8: The block index is `acc_addr[AW-1:9]`. Bitmap word k sits at register offset 2+k, and its bit j covers block 32k+j.
- R9: `acc_blocked` follows the request in the same cycle. A blocked request drives `mem_req` low and `acc_rdata` to 0. An allowed request drives `mem_req` equal to `acc_valid` and passes `mem_rdata` through to `acc_rdata`.
- R10: Each cycle with a blocked valid request produces `illegal_pulse` high for exactly the following cycle. It also sets status bit 0 (offset 1). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R11: `clk_secure` (1 = secure) equals "at least one bitmap bit is 1" XOR the invert field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| acc_valid | input | 1 | Access request valid |
| acc_addr | input | AW | Byte address inside the SRAM |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_secure | input | 1 | Requester is secure |
| acc_wdata | input | 32 | Write data from requester |
| acc_rdata | output | 32 | Read data to requester, 0 when blocked |
| acc_blocked | output | 1 | Current request is illegal |
| illegal_pulse | output | 1 | One-cycle illegal-access event |
| mem_req | output | 1 | Forwarded request to the SRAM |
| mem_addr | output | AW | Forwarded address |
| mem_kind | output | 2 | Forwarded access kind |
| mem_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | Read data from the SRAM |
| clk_secure | output | 1 | Clock-security state, 1 = secure |

## Verification
The bench builds the block with the default `SRAM_BYTES` of 32768. This gives 64 blocks held in two bitmap words, so the first and last blocks and both sides of the word boundary (blocks 31/32 and 62/63) can be reached. Addresses at the first and last byte of a block check the index slice. With both bitmap words live, the clock-security output can be checked with secure bits in either word and with none.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
    localparam int BLK_SHIFT    = 9;
    localparam int WORD_BITS    = 32;
    localparam int OFF_CTL      = 0;
    localparam int OFF_STAT     = 1;
    localparam int OFF_MAP      = 2;
    localparam int CTL_LOCK_BIT = 0;
    localparam int CTL_INV_BIT  = 30;
    localparam int CTL_DIS_BIT  = 31;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic lock;
        logic inv;
        logic dis;
    } ctl_t;
endpackage

// File: rtl/sbg_regs.sv
module sbg_regs
    import sbg_pkg::*;
#(
    parameter int NBLK   = 64,
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              illegal_evt,
    output ctl_t              ctl,
    output logic [NBLK-1:0]   bitmap,
    output logic              illegal_pulse
);
    localparam int NWORDS = NBLK / WORD_BITS;

    typedef struct packed {
        ctl_t            ctl;
        logic            flag;
        logic            pulse;
        logic [NBLK-1:0] map;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = illegal_evt;
        if (reg_wr && reg_addr == REG_AW'(OFF_CTL) && !st_q.ctl.lock) begin
            st_d.ctl.lock = reg_wdata[CTL_LOCK_BIT];
            st_d.ctl.inv  = reg_wdata[CTL_INV_BIT];
            st_d.ctl.dis  = reg_wdata[CTL_DIS_BIT];
        end
        if (reg_wr && reg_addr == REG_AW'(OFF_STAT) && reg_wdata[0]) begin
            st_d.flag = 1'b0;
        end
        if (illegal_evt) begin
            st_d.flag = 1'b1;
        end
        for (int w = 0; w < NWORDS; w++) begin
            if (reg_wr && reg_addr == REG_AW'(OFF_MAP + w)) begin
                st_d.map[w*WORD_BITS +: WORD_BITS] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFF_CTL)) begin
            reg_rdata[CTL_LOCK_BIT] = st_q.ctl.lock;
            reg_rdata[CTL_INV_BIT]  = st_q.ctl.inv;
            reg_rdata[CTL_DIS_BIT]  = st_q.ctl.dis;
        end else if (reg_addr == REG_AW'(OFF_STAT)) begin
            reg_rdata[0] = st_q.flag;
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                if (reg_addr == REG_AW'(OFF_MAP + w)) begin
                    reg_rdata = st_q.map[w*WORD_BITS +: WORD_BITS];
                end
            end
        end
    end

    assign ctl           = st_q.ctl;
    assign bitmap        = st_q.map;
    assign illegal_pulse = st_q.pulse;
endmodule

// File: rtl/sbg_decide.sv
module sbg_decide
    import sbg_pkg::*;
#(
    parameter int NBLK = 64,
    parameter int BW   = 6
) (
    input  logic            acc_valid,
    input  logic [BW-1:0]   blk_idx,
    input  logic [1:0]      acc_kind,
    input  logic            acc_secure,
    input  logic [NBLK-1:0] bitmap,
    input  ctl_t            ctl,
    input  logic [31:0]     mem_rdata,
    output logic            blk_is_sec,
    output logic            acc_blocked,
    output logic            mem_req,
    output logic [31:0]     acc_rdata,
    output logic            clk_secure
);
    logic is_fetch;
    logic illegal;

    always_comb begin
        blk_is_sec = bitmap[blk_idx];
        is_fetch   = (acc_kind == KIND_FETCH);
        illegal    = 1'b0;
        if (!acc_secure && blk_is_sec) begin
            illegal = 1'b1;
        end else if (acc_secure && !blk_is_sec) begin
            illegal = is_fetch || !ctl.dis;
        end
        acc_blocked = acc_valid && illegal;
        mem_req     = acc_valid && !illegal;
        acc_rdata   = illegal ? 32'h0 : mem_rdata;
        clk_secure  = (|bitmap) ^ ctl.inv;
    end
endmodule

// File: rtl/sram_blk_guard.sv
module sram_blk_guard
    import sbg_pkg::*;
#(
    parameter int SRAM_BYTES = 32768
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [$clog2(2+SRAM_BYTES/16384)-1:0] reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          acc_valid,
    input  logic [$clog2(SRAM_BYTES)-1:0] acc_addr,
    input  logic [1:0]                    acc_kind,
    input  logic                          acc_secure,
    input  logic [31:0]                   acc_wdata,
    output logic [31:0]                   acc_rdata,
    output logic                          acc_blocked,
    output logic                          illegal_pulse,
    output logic                          mem_req,
    output logic [$clog2(SRAM_BYTES)-1:0] mem_addr,
    output logic [1:0]                    mem_kind,
    output logic [31:0]                   mem_wdata,
    input  logic [31:0]                   mem_rdata,
    output logic                          clk_secure
);
    localparam int AW     = $clog2(SRAM_BYTES);
    localparam int NBLK   = SRAM_BYTES >> BLK_SHIFT;
    localparam int BW     = AW - BLK_SHIFT;
    localparam int NWORDS = NBLK / WORD_BITS;
    localparam int REG_AW = $clog2(OFF_MAP + NWORDS);

    ctl_t            ctl;
    logic [NBLK-1:0] bitmap;
    logic            blk_is_sec;
    logic            ctl_lock, ctl_inv, ctl_dis;

    sbg_regs #(.NBLK(NBLK), .REG_AW(REG_AW)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .illegal_evt   (acc_blocked),
        .ctl           (ctl),
        .bitmap        (bitmap),
        .illegal_pulse (illegal_pulse)
    );

    sbg_decide #(.NBLK(NBLK), .BW(BW)) decide_i (
        .acc_valid   (acc_valid),
        .blk_idx     (acc_addr[AW-1:BLK_SHIFT]),
        .acc_kind    (acc_kind),
        .acc_secure  (acc_secure),
        .bitmap      (bitmap),
        .ctl         (ctl),
        .mem_rdata   (mem_rdata),
        .blk_is_sec  (blk_is_sec),
        .acc_blocked (acc_blocked),
        .mem_req     (mem_req),
        .acc_rdata   (acc_rdata),
        .clk_secure  (clk_secure)
    );

    assign ctl_lock  = ctl.lock;
    assign ctl_inv   = ctl.inv;
    assign ctl_dis   = ctl.dis;
    assign mem_addr  = acc_addr;
    assign mem_kind  = acc_kind;
    assign mem_wdata = acc_wdata;
endmodule

// File: rtl/sbg_chk.sv
module sbg_chk #(
    parameter int NBLK   = 64,
    parameter int REG_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic              acc_secure,
    input logic              acc_blocked,
    input logic              mem_req,
    input logic              illegal_pulse,
    input logic              clk_secure,
    input logic              ctl_lock,
    input logic              ctl_inv,
    input logic              ctl_dis,
    input logic              blk_is_sec,
    input logic [NBLK-1:0]   bitmap
);
    // R2
    lock_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_lock |=> ctl_lock);
    // R2
    locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_lock && reg_wr && reg_addr == '0) |=> $stable({ctl_inv, ctl_dis}));
    // R4
    sec_data_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_secure && acc_kind != 2'd2 && !blk_is_sec && !ctl_dis) |-> acc_blocked);
    // R6
    sec_fetch_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_secure && acc_kind == 2'd2 && !blk_is_sec) |-> acc_blocked);
    // R7
    ns_to_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_secure && blk_is_sec) |-> acc_blocked);
    // R9
    no_fwd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (acc_valid && !acc_blocked));
    // R10
    pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_blocked) |=> illegal_pulse);
    // R11
    clk_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_inv && bitmap == '0) |-> !clk_secure);
endmodule

bind sram_blk_guard sbg_chk #(.NBLK(NBLK), .REG_AW(REG_AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .acc_valid     (acc_valid),
    .acc_kind      (acc_kind),
    .acc_secure    (acc_secure),
    .acc_blocked   (acc_blocked),
    .mem_req       (mem_req),
    .illegal_pulse (illegal_pulse),
    .clk_secure    (clk_secure),
    .ctl_lock      (ctl_lock),
    .ctl_inv       (ctl_inv),
    .ctl_dis       (ctl_dis),
    .blk_is_sec    (blk_is_sec),
    .bitmap        (bitmap)
);

// File: tb/sram_blk_guard_tb_top.sv
`timescale 1ns/1ps
module sram_blk_guard_tb_top;
    localparam int SRAM_BYTES = 32768;
    localparam int AW         = 15;
    localparam int RAW        = 2;
    localparam logic [31:0] MEMVAL = 32'hCAFE_0001;

    // {addr[14:0], kind[1:0], secure, expect_blocked}, waiver 0,
    // bitmap word0 = 0x5 (blocks 0,2), word1 = 0x8000_0000 (block 63)
    localparam logic [18:0] VEC [11] = '{
        {15'h0000, 2'd0, 1'b1, 1'b0},
        {15'h0000, 2'd0, 1'b0, 1'b1},
        {15'h0200, 2'd1, 1'b1, 1'b1},
        {15'h0200, 2'd0, 1'b0, 1'b0},
        {15'h0400, 2'd2, 1'b0, 1'b1},
        {15'h05FF, 2'd2, 1'b1, 1'b0},
        {15'h0600, 2'd2, 1'b1, 1'b1},
        {15'h7E00, 2'd1, 1'b0, 1'b1},
        {15'h7DFF, 2'd0, 1'b1, 1'b1},
        {15'h7DFF, 2'd0, 1'b0, 1'b0},
        {15'h4000, 2'd1, 1'b0, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           acc_valid = 1'b0;
    logic [AW-1:0]  acc_addr = '0;
    logic [1:0]     acc_kind = '0;
    logic           acc_secure = 1'b0;
    logic [31:0]    acc_wdata = 32'h1234_5678;
    logic [31:0]    acc_rdata;
    logic           acc_blocked, illegal_pulse, mem_req, clk_secure;
    logic [AW-1:0]  mem_addr;
    logic [1:0]     mem_kind;
    logic [31:0]    mem_wdata;
    logic [31:0]    mem_rdata = MEMVAL;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    sram_blk_guard #(.SRAM_BYTES(SRAM_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_secure(acc_secure),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_blocked(acc_blocked),
        .illegal_pulse(illegal_pulse), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_kind(mem_kind), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .clk_secure(clk_secure)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [RAW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [RAW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic access(input string req, input logic [AW-1:0] a, input logic [1:0] k,
                          input logic s, input logic exp_blk);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_secure = s;
        #2;
        chk({req, " blocked"}, {31'd0, acc_blocked}, {31'd0, exp_blk});
        chk("R9 mem_req", {31'd0, mem_req}, {31'd0, !exp_blk});
        chk("R9 rdata", acc_rdata, exp_blk ? 32'h0 : MEMVAL);
        @(posedge clk);
        #2;
        chk("R10 pulse", {31'd0, illegal_pulse}, {31'd0, exp_blk});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(0, rd); chk("R1 ctl", rd, 32'h0);
        rd_reg(1, rd); chk("R1 status", rd, 32'h0);
        rd_reg(2, rd); chk("R1 map0", rd, 32'h0);
        rd_reg(3, rd); chk("R1 map1", rd, 32'h0);
        chk("R1 clk_secure", {31'd0, clk_secure}, 32'h0);
        chk("R1 pulse", {31'd0, illegal_pulse}, 32'h0);

        // R8 bitmap programming and readback
        wr_reg(2, 32'h0000_0005);
        wr_reg(3, 32'h8000_0000);
        rd_reg(2, rd); chk("R8 map0", rd, 32'h0000_0005);
        rd_reg(3, rd); chk("R8 map1", rd, 32'h8000_0000);
        chk("R11 any secure", {31'd0, clk_secure}, 32'h1);

        // R4 R6 R7 R8 decision table with waiver clear
        for (int i = 0; i < 11; i++) begin
            access("R4/R6/R7 table", VEC[i][18:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
        end
        #2;
        chk("R10 pulse drops", {31'd0, illegal_pulse}, 32'h0);

        // R10 sticky flag and write-one-to-clear
        rd_reg(1, rd); chk("R10 flag set", rd, 32'h1);
        wr_reg(1, 32'h0);
        rd_reg(1, rd); chk("R10 write 0 keeps", rd, 32'h1);
        wr_reg(1, 32'h1);
        rd_reg(1, rd); chk("R10 write 1 clears", rd, 32'h0);

        // R3 R5 waiver on
        wr_reg(0, 32'h8000_0000);
        rd_reg(0, rd); chk("R3 waiver field", rd, 32'h8000_0000);
        access("R5 secure write ns", 15'h0200, 2'd1, 1'b1, 1'b0);
        access("R5 secure read ns", 15'h7DFF, 2'd0, 1'b1, 1'b0);
        access("R6 fetch with waiver", 15'h0600, 2'd2, 1'b1, 1'b1);
        access("R7 ns write secure", 15'h0000, 2'd1, 1'b0, 1'b1);

        // R3 R11 invert; unused bits read 0
        wr_reg(0, 32'h7FFF_FFFE);
        rd_reg(0, rd); chk("R3 invert only", rd, 32'h4000_0000);
        chk("R11 inverted with secure", {31'd0, clk_secure}, 32'h0);
        wr_reg(2, 32'h0);
        wr_reg(3, 32'h0);
        chk("R11 inverted no secure", {31'd0, clk_secure}, 32'h1);

        // R2 lock
        wr_reg(0, 32'h0000_0001);
        rd_reg(0, rd); chk("R2 locked", rd, 32'h1);
        chk("R11 plain no secure", {31'd0, clk_secure}, 32'h0);
        wr_reg(0, 32'hC000_0000);
        rd_reg(0, rd); chk("R2 write ignored", rd, 32'h1);
        wr_reg(0, 32'h0);
        rd_reg(0, rd); chk("R2 lock stays", rd, 32'h1);
        access("R2 waiver stays off", 15'h0200, 2'd0, 1'b1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule